// File: doc/BRIEF.md
# E1/T1 Data-Link Channel Selector

This block sits between a line framer and a bit-serial HDLC controller. It decides which bit positions of the framed E1 or T1 stream carry the data link. On the receive side it raises a one-cycle enable, with the received bit, for each selected position. On the transmit side it asks the HDLC controller for a bit at each selected position and puts that bit into the outgoing stream. Every other bit of the stream passes through unchanged.

The framer supplies a bit-period tick together with the timeslot, bit and frame position of that bit. In T1 mode it also marks the framing-bit period. The link source can be one of four settings: none, the national-use bits of E1 timeslot 0 (any subset of the five, giving 4 to 20 kb/s), the T1 framing bit in odd frames (4 kb/s), or one whole 64 kb/s timeslot. Configuration is shadowed and only takes effect at a frame boundary. Settings that are illegal for the current line mode are turned into "none". In E1 mode the five national-use bits are also held in a 5-bit register whatever the link selection is.

Top module: `dl_link_sel`

## Requirements
- R1: While and right after reset, `dl_rx_en` and `dl_tx_req` are 0, `sa_nat` is 0, `line_tx_out` equals `line_tx_in`, and the active source is none.
- R2: With `cfg_src`=1 (national bits) in E1 mode, a position is selected only when all of these hold: the frame is odd, `ts_cnt`=0, `bit_cnt`≥3, and `cfg_sa_mask[bit_cnt-3]` is 1. `bit_cnt` 0 is the first bit sent (MSB), so mask bit 0 selects bit index 3 and mask bit 4 selects bit index 7.
- R3: With `cfg_src`=2 (framing bit) in T1 mode, a position is selected only at a tick with `fbit_slot`=1 and `frame_odd`=1.
- R4: With `cfg_src`=3 (channel), all eight bit positions of timeslot `cfg_chan` are selected, and no framing-bit period is selected.
- R5: An illegal setting selects nothing. The illegal settings are: channel 0 in E1 mode, a channel number of 24 or more in T1 mode, national bits in T1 mode, and the framing bit in E1 mode.
- R6: With `cfg_src`=0 nothing is selected.
- R7: `dl_tx_req` is high in the same cycle as the `bit_tick` of a selected position and is low in every other cycle. `line_tx_out` is `dl_tx_bit` while `dl_tx_req` is high and `line_tx_in` otherwise.
- R8: `dl_rx_en` is high for exactly the one cycle after each selected tick. In that cycle `dl_rx_bit` holds `line_rx_bit` as it was at the tick.
- R9: In E1 mode, the received bit at indices 3..7 of timeslot 0 in odd frames is stored in `sa_nat[bit_cnt-3]`, whatever the link setting is. Even frames and T1 mode leave `sa_nat` unchanged.
- R10: `e1_mode`, `cfg_src`, `cfg_sa_mask` and `cfg_chan` are sampled only in a cycle with `frame_sync` high. A change at any other time has no effect until the next `frame_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle marker of a line bit period |
| frame_sync | input | 1 | Frame boundary pulse; loads configuration |
| frame_odd | input | 1 | Current frame is odd-numbered |
| fbit_slot | input | 1 | T1 framing-bit period (0 in E1) |
| ts_cnt | input | 5 | Current timeslot |
| bit_cnt | input | 3 | Bit within timeslot, 0 first sent |
| e1_mode | input | 1 | 1 = E1, 0 = T1 |
| cfg_src | input | 2 | Link source: 0 none, 1 national bits, 2 framing bit, 3 channel |
| cfg_sa_mask | input | 5 | National-bit enables, bit 0 = first national bit |
| cfg_chan | input | 5 | Timeslot for channel mode |
| line_rx_bit | input | 1 | Received line bit |
| dl_rx_en | output | 1 | Receive bit valid toward HDLC |
| dl_rx_bit | output | 1 | Receive bit toward HDLC |
| dl_tx_bit | input | 1 | Transmit bit from HDLC |
| dl_tx_req | output | 1 | Transmit bit taken from HDLC this cycle |
| line_tx_in | input | 1 | Outgoing line bit before insertion |
| line_tx_out | output | 1 | Outgoing line bit after insertion |
| sa_nat | output | 5 | Latched national-use bits |

## Verification
The checker watches these rules on every cycle:
- Requests happen only on ticks, and pass-through holds whenever no request is made.
- The receive enable follows the transmit request by exactly one cycle and carries the bit seen at the tick.
- Nothing is selected while the source is none.
- In E1 channel mode timeslot 0 is never used.
- National-bit selections fall only in timeslot 0 of odd frames.
- The active configuration never changes except after a frame boundary.

Only the bench's sweeps can show the rest:
- The exact mask-to-bit mapping.
- That a chosen channel delivers all eight of its bits.
- That illegal settings are screened out.
- What the latched national-bit register holds after each frame.

// File: rtl/dl_link_pkg.sv
package dl_link_pkg;

    localparam int TS_W      = 5;
    localparam int BIT_W     = 3;
    localparam int NAT_N     = 5;
    localparam int SLOT_BITS = 1 << BIT_W;
    localparam int NAT_FIRST = SLOT_BITS - NAT_N;

    typedef enum logic [1:0] {
        LINK_OFF     = 2'd0,
        LINK_NATBITS = 2'd1,
        LINK_FBIT    = 2'd2,
        LINK_CHAN    = 2'd3
    } link_src_e;

    typedef struct packed {
        logic             e1;
        link_src_e        src;
        logic [NAT_N-1:0] sa_mask;
        logic [TS_W-1:0]  chan;
    } link_cfg_t;

    typedef struct packed {
        logic             tick;
        logic             odd;
        logic             fbit;
        logic [TS_W-1:0]  ts;
        logic [BIT_W-1:0] bitn;
    } line_pos_t;

    // Turns a source that is illegal in the chosen line mode into LINK_OFF
    function automatic link_src_e screen_src(link_cfg_t c, int t1_slots);
        link_src_e r;
        case (c.src)
            LINK_NATBITS: r = c.e1 ? LINK_NATBITS : LINK_OFF;
            LINK_FBIT:    r = c.e1 ? LINK_OFF : LINK_FBIT;
            LINK_CHAN: begin
                if (c.e1) r = (c.chan != '0) ? LINK_CHAN : LINK_OFF;
                else      r = (32'(c.chan) < t1_slots) ? LINK_CHAN : LINK_OFF;
            end
            default:      r = LINK_OFF;
        endcase
        return r;
    endfunction

    // True inside the national-bit window of timeslot 0 in an odd frame
    function automatic logic in_nat_window(line_pos_t p);
        return !p.fbit && p.odd && (p.ts == '0) && (p.bitn >= BIT_W'(NAT_FIRST));
    endfunction

endpackage

// File: rtl/dl_cfg_shadow.sv
module dl_cfg_shadow
    import dl_link_pkg::*;
#(
    parameter int T1_SLOTS = 24
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  link_cfg_t cfg_in,
    output link_cfg_t act
);

    link_cfg_t screened;

    always_comb begin
        screened     = cfg_in;
        screened.src = screen_src(cfg_in, T1_SLOTS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '{e1: 1'b1, src: LINK_OFF, sa_mask: '0, chan: '0};
        end else if (load) begin
            act <= screened;
        end
    end

endmodule

// File: rtl/dl_pos_match.sv
module dl_pos_match
    import dl_link_pkg::*;
(
    input  line_pos_t        pos,
    input  link_cfg_t        act,
    output logic             hit,
    output logic             nat_tick,
    output logic [BIT_W-1:0] nat_idx
);

    logic             nat_win;
    logic [NAT_N-1:0] nat_onehot;
    logic             sel;

    always_comb begin
        nat_win    = in_nat_window(pos);
        nat_idx    = pos.bitn - BIT_W'(NAT_FIRST);
        nat_onehot = NAT_N'(1) << nat_idx;
        case (act.src)
            LINK_NATBITS: sel = nat_win && |(act.sa_mask & nat_onehot);
            LINK_FBIT:    sel = pos.fbit && pos.odd;
            LINK_CHAN:    sel = !pos.fbit && (pos.ts == act.chan);
            default:      sel = 1'b0;
        endcase
        hit      = pos.tick && sel;
        nat_tick = pos.tick && nat_win && act.e1;
    end

endmodule

// File: rtl/dl_rx_capture.sv
module dl_rx_capture
    import dl_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             nat_tick,
    input  logic [BIT_W-1:0] nat_idx,
    input  logic             rx_bit,
    output logic             rx_en_q,
    output logic             rx_bit_q,
    output logic [NAT_N-1:0] nat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en_q  <= 1'b0;
            rx_bit_q <= 1'b0;
        end else begin
            rx_en_q  <= hit;
            rx_bit_q <= hit ? rx_bit : 1'b0;
        end
    end

    for (genvar g = 0; g < NAT_N; g++) begin : g_nat
        always_ff @(posedge clk) begin
            if (rst) begin
                nat_q[g] <= 1'b0;
            end else if (nat_tick && (nat_idx == BIT_W'(g))) begin
                nat_q[g] <= rx_bit;
            end
        end
    end

endmodule

// File: rtl/dl_link_sel.sv
module dl_link_sel
    import dl_link_pkg::*;
#(
    parameter int T1_SLOTS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             frame_sync,
    input  logic             frame_odd,
    input  logic             fbit_slot,
    input  logic [TS_W-1:0]  ts_cnt,
    input  logic [BIT_W-1:0] bit_cnt,
    input  logic             e1_mode,
    input  logic [1:0]       cfg_src,
    input  logic [NAT_N-1:0] cfg_sa_mask,
    input  logic [TS_W-1:0]  cfg_chan,
    input  logic             line_rx_bit,
    output logic             dl_rx_en,
    output logic             dl_rx_bit,
    input  logic             dl_tx_bit,
    output logic             dl_tx_req,
    input  logic             line_tx_in,
    output logic             line_tx_out,
    output logic [NAT_N-1:0] sa_nat
);

    link_cfg_t        cfg_raw;
    link_cfg_t        act_q;
    line_pos_t        pos;
    logic             hit;
    logic             nat_tick;
    logic [BIT_W-1:0] nat_idx;

    always_comb begin
        cfg_raw = '{e1: e1_mode, src: link_src_e'(cfg_src),
                    sa_mask: cfg_sa_mask, chan: cfg_chan};
        pos     = '{tick: bit_tick, odd: frame_odd, fbit: fbit_slot,
                    ts: ts_cnt, bitn: bit_cnt};
    end

    dl_cfg_shadow #(.T1_SLOTS(T1_SLOTS)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_sync),
        .cfg_in (cfg_raw),
        .act    (act_q)
    );

    dl_pos_match u_match (
        .pos      (pos),
        .act      (act_q),
        .hit      (hit),
        .nat_tick (nat_tick),
        .nat_idx  (nat_idx)
    );

    dl_rx_capture u_rx (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .nat_tick (nat_tick),
        .nat_idx  (nat_idx),
        .rx_bit   (line_rx_bit),
        .rx_en_q  (dl_rx_en),
        .rx_bit_q (dl_rx_bit),
        .nat_q    (sa_nat)
    );

    always_comb begin
        dl_tx_req   = hit;
        line_tx_out = hit ? dl_tx_bit : line_tx_in;
    end

endmodule

// File: rtl/dl_link_sel_chk.sv
module dl_link_sel_chk
    import dl_link_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bit_tick,
    input logic            frame_sync,
    input logic            frame_odd,
    input logic            fbit_slot,
    input logic [TS_W-1:0] ts_cnt,
    input logic            line_rx_bit,
    input logic            line_tx_in,
    input logic            line_tx_out,
    input logic            dl_tx_req,
    input logic            dl_rx_en,
    input logic            dl_rx_bit,
    input logic            act_e1,
    input link_src_e       act_src
);

    // R7
    req_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        dl_tx_req |-> bit_tick);

    // R7
    tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !dl_tx_req |-> (line_tx_out == line_tx_in));

    // R8
    rx_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dl_rx_en |-> $past(dl_tx_req));

    // R8
    rx_bit_chk: assert property (@(posedge clk) disable iff (rst)
        dl_rx_en |-> (dl_rx_bit == $past(line_rx_bit)));

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (act_src == LINK_OFF) |-> !dl_tx_req);

    // R5
    no_ts0_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (act_e1 && act_src == LINK_CHAN && dl_tx_req) |-> (ts_cnt != '0 && !fbit_slot));

    // R2
    nat_place_chk: assert property (@(posedge clk) disable iff (rst)
        (act_src == LINK_NATBITS && dl_tx_req) |-> (ts_cnt == '0 && frame_odd));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_sync) |-> ($stable(act_src) && $stable(act_e1)));

endmodule

bind dl_link_sel dl_link_sel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .frame_sync  (frame_sync),
    .frame_odd   (frame_odd),
    .fbit_slot   (fbit_slot),
    .ts_cnt      (ts_cnt),
    .line_rx_bit (line_rx_bit),
    .line_tx_in  (line_tx_in),
    .line_tx_out (line_tx_out),
    .dl_tx_req   (dl_tx_req),
    .dl_rx_en    (dl_rx_en),
    .dl_rx_bit   (dl_rx_bit),
    .act_e1      (act_q.e1),
    .act_src     (act_q.src)
);

// File: tb/test_dl_link_sel.sv
module test_dl_link_sel;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick, frame_sync, frame_odd, fbit_slot;
    logic [4:0] ts_cnt;
    logic [2:0] bit_cnt;
    logic       e1_mode;
    logic [1:0] cfg_src;
    logic [4:0] cfg_sa_mask, cfg_chan;
    logic       line_rx_bit, dl_rx_en, dl_rx_bit, dl_tx_bit, dl_tx_req;
    logic       line_tx_in, line_tx_out;
    logic [4:0] sa_nat;

    always #(CLK_PERIOD/2) clk = ~clk;

    dl_link_sel i_dl_link_sel (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .frame_odd(frame_odd), .fbit_slot(fbit_slot), .ts_cnt(ts_cnt),
        .bit_cnt(bit_cnt), .e1_mode(e1_mode), .cfg_src(cfg_src),
        .cfg_sa_mask(cfg_sa_mask), .cfg_chan(cfg_chan),
        .line_rx_bit(line_rx_bit), .dl_rx_en(dl_rx_en), .dl_rx_bit(dl_rx_bit),
        .dl_tx_bit(dl_tx_bit), .dl_tx_req(dl_tx_req), .line_tx_in(line_tx_in),
        .line_tx_out(line_tx_out), .sa_nat(sa_nat)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    fno     = 0;
    bit    cur_e1, alt_e1;
    int    cur_src, cur_mask, cur_chan;
    int    alt_src, alt_mask, alt_chan;
    string cur_tag;
    logic [4:0] exp_sa = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int actual, input int expected);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    function automatic bit rx_of(int f, int ts, int b);
        return 1'(((f * 13 + ts * 7 + b * 3) >> 1) & 1);
    endfunction
    function automatic bit txin_of(int f, int ts, int b);
        return 1'((f + ts + b) & 1);
    endfunction
    function automatic bit dlt_of(int f, int ts, int b);
        return 1'(((f * 5 + ts * 3 + b) >> 2) & 1);
    endfunction

    // Expected selection from the requirements (R2..R6)
    function automatic bit exp_sel(int src, bit e1, int mask, int chan,
                                   bit odd, bit fb, int ts, int b);
        case (src)
            1: return e1 && odd && !fb && ts == 0 && b >= 3 && (((mask >> (b - 3)) & 1) == 1);
            2: return !e1 && odd && fb;
            3: return !fb && ts == chan && (e1 ? (chan != 0) : (chan < 24));
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_cfg(input bit e1, input int src, input int mask, input int chan);
        e1_mode     = e1;
        cfg_src     = 2'(src);
        cfg_sa_mask = 5'(mask);
        cfg_chan    = 5'(chan);
    endtask

    task automatic do_bit(input int f, input bit fb, input int ts, input int b, input bit esel);
        bit rxv, txv, dlv;
        rxv = rx_of(f, ts, b);
        txv = txin_of(f, ts, b);
        dlv = dlt_of(f, ts, b);
        @(negedge clk);
        bit_tick = 1'b1; frame_odd = f[0]; fbit_slot = fb;
        ts_cnt = 5'(ts); bit_cnt = 3'(b);
        line_rx_bit = rxv; line_tx_in = txv; dl_tx_bit = dlv;
        #1;
        chk(dl_tx_req === esel, cur_tag, "tx_req", int'(dl_tx_req), int'(esel));
        chk(line_tx_out === (esel ? dlv : txv), "R7", "line_tx_out",
            int'(line_tx_out), int'(esel ? dlv : txv));
        @(negedge clk);
        chk(dl_rx_en === esel, "R8", "rx_en", int'(dl_rx_en), int'(esel));
        if (esel) chk(dl_rx_bit === rxv, "R8", "rx_bit", int'(dl_rx_bit), int'(rxv));
        bit_tick = 1'b0; line_tx_in = ~txv;
        #1;
        chk(dl_tx_req === 1'b0 && line_tx_out === line_tx_in, "R7", "idle cycle",
            int'(line_tx_out), int'(line_tx_in));
    endtask

    task automatic run_frame(input bit mid);
        int  f = fno;
        bit  e1 = cur_e1;
        bit  odd = f[0];
        int  nslots = e1 ? 32 : 24;
        @(negedge clk);
        drive_cfg(cur_e1, cur_src, cur_mask, cur_chan);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        if (!e1) do_bit(f, 1'b1, 0, 0, exp_sel(cur_src, e1, cur_mask, cur_chan, odd, 1'b1, 0, 0));
        for (int ts = 0; ts < nslots; ts++) begin
            for (int b = 0; b < 8; b++) begin
                if (mid && ts == 4 && b == 0) drive_cfg(alt_e1, alt_src, alt_mask, alt_chan);
                if (e1 && odd && ts == 0 && b >= 3) exp_sa[b - 3] = rx_of(f, ts, b);
                do_bit(f, 1'b0, ts, b, exp_sel(cur_src, e1, cur_mask, cur_chan, odd, 1'b0, ts, b));
            end
        end
        chk(sa_nat === exp_sa, "R9", "sa_nat", int'(sa_nat), int'(exp_sa));
        fno++;
    endtask

    task automatic set_cur(input bit e1, input int src, input int mask, input int chan,
                           input string tag);
        cur_e1 = e1; cur_src = src; cur_mask = mask; cur_chan = chan; cur_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_tick = 0; frame_sync = 0; frame_odd = 0; fbit_slot = 0;
        ts_cnt = 0; bit_cnt = 0; line_rx_bit = 0; dl_tx_bit = 0; line_tx_in = 1;
        drive_cfg(1'b1, 0, 0, 0);
        alt_e1 = 1'b1; alt_src = 0; alt_mask = 0; alt_chan = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(dl_rx_en === 1'b0, "R1", "rx_en", int'(dl_rx_en), 0);
        chk(dl_tx_req === 1'b0, "R1", "tx_req", int'(dl_tx_req), 0);
        chk(sa_nat === 5'd0, "R1", "sa_nat", int'(sa_nat), 0);
        chk(line_tx_out === 1'b1, "R1", "line_tx_out", int'(line_tx_out), 1);

        // R6 source off
        set_cur(1'b1, 0, 5'h1f, 3, "R6");
        repeat (2) run_frame(1'b0);

        // R2 every national-bit mask, even and odd frame
        for (int m = 0; m < 32; m++) begin
            set_cur(1'b1, 1, m, 0, "R2");
            run_frame(1'b0);
            run_frame(1'b0);
        end

        // R4 every legal E1 channel
        for (int c = 1; c < 32; c++) begin
            set_cur(1'b1, 3, 0, c, "R4");
            run_frame(1'b0);
        end

        // R5 illegal settings
        set_cur(1'b1, 3, 0, 0, "R5");
        run_frame(1'b0);
        set_cur(1'b1, 2, 0, 0, "R5");
        repeat (2) run_frame(1'b0);
        set_cur(1'b0, 1, 5'h1f, 0, "R5");
        repeat (2) run_frame(1'b0);   // also R9: T1 leaves sa_nat unchanged
        for (int c = 24; c < 32; c++) begin
            set_cur(1'b0, 3, 0, c, "R5");
            run_frame(1'b0);
        end

        // R3 T1 framing bit
        set_cur(1'b0, 2, 0, 0, "R3");
        repeat (4) run_frame(1'b0);

        // R4 every T1 channel
        for (int c = 0; c < 24; c++) begin
            set_cur(1'b0, 3, 0, c, "R4");
            run_frame(1'b0);
        end

        // R10 mid-frame change has no effect until next boundary
        set_cur(1'b1, 0, 0, 0, "R10");
        alt_e1 = 1'b0; alt_src = 3; alt_mask = 0; alt_chan = 9;
        run_frame(1'b1);
        set_cur(1'b1, 1, 5'h15, 0, "R10");
        alt_e1 = 1'b1; alt_src = 3; alt_mask = 0; alt_chan = 9;
        if (fno % 2 == 0) run_frame(1'b0);
        run_frame(1'b1);
        set_cur(1'b1, 3, 0, 9, "R10");
        run_frame(1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule